// File: doc/BRIEF.md
# Stereo Soft-Mute Gain Ramp

This block sits in the digital sample path of a stereo converter, ahead of interpolation and modulation. It multiplies every left and right two's-complement sample by a gain that glides between unity and silence. The gain moves by one step on each frame strobe, so one step is taken per stereo sample pair. A full fade in either direction takes 1024 frames.

Raising the mute request starts the fade towards silence. Lowering it sends the gain back up to unity. A fade that is still running turns around from the level it has reached, so the gain never jumps. A status flag reports when the signal is fully silenced. The block suits source changes that must be made without halting the sample stream.

Top module: `audio_fade_mute`

## Requirements
- R1: A synchronous active-high reset sets the gain to unity (1024), drives both sample outputs to zero and holds the muted flag low.
- R2: With the mute request high, each frame strobe lowers the gain by one. From unity it reaches zero after 1024 strobes and then stays at zero.
- R3: With the mute request low, each frame strobe raises the gain by one until it reaches 1024, where it stays.
- R4: If the mute request falls while the gain is between 0 and 1024, the next strobe raises the gain from that level. If the request rises mid-climb, the next strobe lowers it from that level. No step is ever larger than one.
- R5: On a frame strobe, each output register loads trunc(sample × gain / 1024), rounded toward zero. The sample is the signed 20-bit input and the gain is the value held before that strobe's step. The result appears on the output one clock after the strobe edge.
- R6: When the gain is 0 at a strobe, both outputs become exactly zero for every input, including the full-scale codes 7FFFFh and 80000h.
- R7: When the gain is 1024 at a strobe, each output equals its input bit for bit, including 7FFFFh and 80000h.
- R8: Without a strobe, the outputs and the gain do not change, whatever the mute request and sample inputs do.
- R9: The muted flag is high exactly while the gain is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle strobe per stereo frame; loads samples and steps the gain |
| mute_req | input | 1 | High requests a fade to silence, low a fade back to unity |
| left_in | input | 20 | Left sample, two's complement |
| right_in | input | 20 | Right sample, two's complement |
| left_out | output | 20 | Attenuated left sample |
| right_out | output | 20 | Attenuated right sample |
| muted | output | 1 | High while the gain is zero |

## Verification
The left channel is fed the constant 1024 throughout, so its output reads the current gain directly. Every gain value is stepped through on the way down, on the way up and across both turn-around points. A reversal that restarts from the wrong level, or a step of the wrong size, therefore shows up on the very next frame. The right channel carries a pseudo-random signed stream plus the two full-scale codes and small negative values. These expose sign handling and rounding toward zero, which a plain arithmetic shift gets wrong for negative products. Idle stretches between strobes, with the mute request and the inputs toggling, separate strobe-gated updates from free-running ones.

// File: rtl/fade_pkg.sv
package fade_pkg;

    // Default sample width and ramp length (2**RAMP_LOG2 frames per fade)
    localparam int SAMPLE_W  = 20;
    localparam int RAMP_LOG2 = 10;

    // Direction taken by the gain counter on a frame strobe
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_UP   = 2'd2
    } step_dir_e;

endpackage

// File: rtl/fade_gain_ramp.sv
module fade_gain_ramp
    import fade_pkg::*;
#(
    parameter int RAMP_LOG2 = fade_pkg::RAMP_LOG2,
    localparam int GAIN_W   = RAMP_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_stb,
    input  logic              mute_req,
    output logic [GAIN_W-1:0] gain,
    output logic              at_zero
);

    localparam logic [GAIN_W-1:0] GAIN_FULL = GAIN_W'(1) << RAMP_LOG2;

    step_dir_e dir;

    // A withdrawn request simply changes the direction; the count carries on
    // from wherever it is, which gives the reversal without any extra state.
    always_comb begin
        dir = STEP_HOLD;
        if (frame_stb) begin
            if (mute_req && (gain != '0))
                dir = STEP_DOWN;
            else if (!mute_req && (gain != GAIN_FULL))
                dir = STEP_UP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain <= GAIN_FULL;
        end else begin
            case (dir)
                STEP_DOWN: gain <= gain - 1'b1;
                STEP_UP:   gain <= gain + 1'b1;
                default:   gain <= gain;
            endcase
        end
    end

    assign at_zero = (gain == '0);

    AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        gain <= GAIN_FULL);                                             // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        frame_stb && mute_req && (gain != '0) |=> gain == $past(gain) - 1'b1);   // R2
    AST_FLOOR_HOLD: assert property (@(posedge clk) disable iff (rst)
        mute_req && (gain == '0) |=> gain == '0);                       // R2
    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        frame_stb && !mute_req && (gain != GAIN_FULL) |=> gain == $past(gain) + 1'b1); // R4
    AST_CEIL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mute_req && (gain == GAIN_FULL) |=> gain == GAIN_FULL);        // R3
    AST_GAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(gain));                                  // R8

endmodule

// File: rtl/fade_scaler.sv
module fade_scaler #(
    parameter int SAMPLE_W  = fade_pkg::SAMPLE_W,
    parameter int RAMP_LOG2 = fade_pkg::RAMP_LOG2,
    localparam int GAIN_W   = RAMP_LOG2 + 1,
    localparam int PROD_W   = SAMPLE_W + GAIN_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       frame_stb,
    input  logic        [GAIN_W-1:0]   gain,
    input  logic signed [SAMPLE_W-1:0] smp_in,
    output logic signed [SAMPLE_W-1:0] smp_out
);

    localparam logic [GAIN_W-1:0]        GAIN_FULL = GAIN_W'(1) << RAMP_LOG2;
    localparam logic signed [PROD_W-1:0] RND_BIAS  = (PROD_W'(1) << RAMP_LOG2) - 1;

    logic signed [PROD_W-1:0]   prod;
    logic signed [PROD_W-1:0]   biased;
    logic signed [SAMPLE_W-1:0] scaled;

    // Negative products get 2**RAMP_LOG2-1 added before the arithmetic shift,
    // turning floor division into truncation toward zero.
    always_comb begin
        prod   = smp_in * $signed({1'b0, gain});
        biased = prod[PROD_W-1] ? prod + RND_BIAS : prod;
        scaled = SAMPLE_W'(biased >>> RAMP_LOG2);
    end

    always_ff @(posedge clk) begin
        if (rst)
            smp_out <= '0;
        else if (frame_stb)
            smp_out <= scaled;
    end

    AST_ZERO_GAIN_SILENT: assert property (@(posedge clk) disable iff (rst)
        frame_stb && (gain == '0) |=> smp_out == '0);                   // R6
    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (rst)
        frame_stb && (gain == GAIN_FULL) |=> smp_out == $past(smp_in)); // R7
    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(smp_out));                               // R8

endmodule

// File: rtl/audio_fade_mute.sv
module audio_fade_mute
    import fade_pkg::*;
#(
    parameter int SAMPLE_W  = fade_pkg::SAMPLE_W,
    parameter int RAMP_LOG2 = fade_pkg::RAMP_LOG2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_stb,
    input  logic                mute_req,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                muted
);

    localparam int GAIN_W  = RAMP_LOG2 + 1;
    localparam int N_CHAN  = 2;

    logic [GAIN_W-1:0]          gain;
    logic signed [SAMPLE_W-1:0] ch_in  [N_CHAN];
    logic signed [SAMPLE_W-1:0] ch_out [N_CHAN];

    assign ch_in[0]  = $signed(left_in);
    assign ch_in[1]  = $signed(right_in);
    assign left_out  = ch_out[0];
    assign right_out = ch_out[1];

    fade_gain_ramp #(
        .RAMP_LOG2 (RAMP_LOG2)
    ) u_ramp (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .mute_req  (mute_req),
        .gain      (gain),
        .at_zero   (muted)
    );

    // One multiplier per channel, both fed the shared gain
    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        fade_scaler #(
            .SAMPLE_W  (SAMPLE_W),
            .RAMP_LOG2 (RAMP_LOG2)
        ) u_scale (
            .clk       (clk),
            .rst       (rst),
            .frame_stb (frame_stb),
            .gain      (gain),
            .smp_in    (ch_in[c]),
            .smp_out   (ch_out[c])
        );
    end

    AST_MUTED_SILENT: assert property (@(posedge clk) disable iff (rst)
        frame_stb && muted |=> (left_out == '0) && (right_out == '0));  // R9
    AST_MUTED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(muted));                                 // R8

endmodule

// File: tb/audio_fade_mute_test.sv
module audio_fade_mute_test;

    localparam int W    = 20;
    localparam int FULL = 1024;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         frame_stb = 1'b0;
    logic         mute_req = 1'b0;
    logic [W-1:0] left_in = '0;
    logic [W-1:0] right_in = '0;
    logic [W-1:0] left_out;
    logic [W-1:0] right_out;
    logic         muted;

    int n_cmp = 0;
    int n_bad = 0;
    int gm = FULL;          // bench model of the gain
    int seed = 32'h1357;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    audio_fade_mute uut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .mute_req(mute_req),
        .left_in(left_in), .right_in(right_in),
        .left_out(left_out), .right_out(right_out), .muted(muted)
    );

    function automatic int to_int(input logic [W-1:0] v);
        return int'($signed(v));
    endfunction

    function automatic int scale(input int s, input int g);
        longint p;
        p = longint'(s) * longint'(g);
        return int'(p / FULL);    // integer division truncates toward zero
    endfunction

    function automatic int next_rand();
        seed = seed * 1103515245 + 12345;
        return int'($signed(seed[W+5:6]));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One frame: strobe with samples, then compare against the model
    task automatic frame(input int l, input int r, input string req);
        int el, er;
        @(negedge clk);
        left_in   = W'(l);
        right_in  = W'(r);
        frame_stb = 1'b1;
        el = scale(l, gm);
        er = scale(r, gm);
        if (mute_req && gm > 0) gm--;
        else if (!mute_req && gm < FULL) gm++;
        @(negedge clk);
        frame_stb = 1'b0;
        check(req, to_int(left_out), el);
        check(req, to_int(right_out), er);
        check("R9", int'(muted), int'(gm == 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", to_int(left_out), 0);
        check("R1", to_int(right_out), 0);
        check("R1", int'(muted), 0);
        rst = 1'b0;
        @(negedge clk);

        // R7: unity passes every value, including both full-scale codes
        frame(32'sh7FFFF, -32'sh80000, "R7");
        frame(-32'sh80000, 32'sh7FFFF, "R7");
        frame(-1, 1, "R7");
        for (int i = 0; i < 40; i++) frame(next_rand(), next_rand(), "R7");
        check("R3", to_int(left_out), to_int(left_in)); // still at unity, held

        // R2/R5: full fade down, left probe 1024 reads the gain
        mute_req = 1'b1;
        for (int i = 0; i < 1030; i++) begin
            if (i % 3 == 0) frame(FULL, next_rand(), "R5");
            else if (i % 3 == 1) frame(FULL, -(i + 1), "R5");
            else frame(FULL, 32'sh7FFFF, "R2");
        end
        check("R2", gm, 0);

        // R6: zero gain silences everything
        frame(32'sh7FFFF, -32'sh80000, "R6");
        frame(-32'sh80000, 32'sh7FFFF, "R6");
        frame(FULL, -1, "R6");

        // R8: idle cycles with toggling inputs change nothing
        mute_req = 1'b0;
        left_in  = 20'h12345;
        right_in = 20'h80001;
        repeat (6) @(negedge clk);
        check("R8", to_int(left_out), 0);
        check("R8", int'(muted), 1);
        frame(FULL, 0, "R8");       // gain was still 0 at this strobe

        // R3/R4: climb part way, reverse down, reverse up again
        for (int i = 0; i < 500; i++) frame(FULL, next_rand(), "R3");
        mute_req = 1'b1;
        for (int i = 0; i < 200; i++) frame(FULL, next_rand(), "R4");
        mute_req = 1'b0;
        for (int i = 0; i < 50; i++) frame(FULL, -(i * 37 + 5), "R4");

        // R8 mid-ramp: mute toggles without strobes
        mute_req = 1'b1;
        repeat (4) @(negedge clk);
        mute_req = 1'b0;
        repeat (4) @(negedge clk);
        frame(FULL, 1023, "R8");

        // R3: finish the climb and hold at unity
        for (int i = 0; i < 900; i++) frame(FULL, next_rand(), "R3");
        check("R3", gm, FULL);
        frame(32'sh7FFFF, -32'sh80000, "R7");

        // R1: reset mid-fade restores unity
        mute_req = 1'b1;
        for (int i = 0; i < 10; i++) frame(FULL, 3, "R2");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        gm = FULL;
        check("R1", to_int(left_out), 0);
        check("R1", int'(muted), 0);
        mute_req = 1'b0;
        frame(FULL, -32'sh80000, "R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule